// File: doc/BRIEF.md
# Authenticated Reset Release Sequencer

This block keeps a processor in reset until the power supply has settled and an authenticator has vouched for the boot. Every rail power-good input and a supply-good input are ANDed together. The result is filtered for glitches and then qualified by a debounce interval plus a minimum high time. Qualification opens a tick counter. An approval that arrives while that counter lies inside a bounded key window releases the reset. An approval that arrives too early, a failure report inside the window, or no approval by the end of the window drives the block into a halted verdict. The verdict follows a per-case policy: stay locked, request degraded operation, or request a key wipe.

All inputs are plain control levels or pulses, and so are all outputs. No data stream passes through the block, so it has no valid/ready interface and no back-pressure. The approval and failure inputs act on a rising edge after filtering. The pre-authorization input is a level. A loss of qualified power-good pulls the reset low in the same cycle it is seen and restarts the whole sequence. After any re-assertion, the reset output stays low for a minimum number of ticks.

Top module: `auth_rst_seq`

## Requirements
- R1: `mcu_rst_n_o` is 0 after `rst_ni` and whenever qualified power-good is absent. It can rise only after power-good has qualified and an approval has been accepted, never before the window opens.
- R2: Raw power-good is `supply_ok_i` AND every bit of `rail_pg_i`. It qualifies only after the filtered level stays high for DEBOUNCE_TICKS+MIN_PULSE_TICKS consecutive ticks. A shorter high never opens the window.
- R3: A level change shorter than GLITCH_TICKS ticks on the raw power-good, `auth_ok_i` or `auth_fail_i` causes no state change.
- R4: Window tick 0 is the first cycle after qualification. A filtered `auth_ok_i` rising edge seen at tick t with KEY_MIN <= t <= KEY_MAX releases the reset, and `cause_o` becomes 0.
- R5: An approval edge at tick t < KEY_MIN is an under-window event. The block halts under `pol_under_i`, and `cause_o` becomes 1.
- R6: If no approval has arrived when the counter reaches KEY_MAX, the event is over-window. The block halts under `pol_over_i`, and `cause_o` becomes 2.
- R7: The policy code is 0 = lock (`lock_o`), 1 = degrade (`degrade_req_o`), 2 = zeroize (`zeroize_req_o`), and 3 = lock. At most one of these three outputs is high, and only while halted.
- R8: A high `preauth_i` is ignored while t < KEY_MIN. From t = KEY_MIN it counts as an approval.
- R9: A filtered `auth_fail_i` rising edge with t >= KEY_MIN halts under `pol_over_i` and sets `cause_o` to 3. It also increments `fail_cnt_o`, which saturates and clears only on `rst_ni`. A failure edge before the window opens is ignored.
- R10: A loss of qualified power-good drops `mcu_rst_n_o` in the same cycle and sets `cause_o` to 4. The next window is timed from the next qualification.
- R11: Each low period of `mcu_rst_n_o` lasts at least RST_MIN_LOW ticks.
- R12: A halted verdict ignores approvals. Its only exit is a loss of power-good followed by requalification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 1 | Primary supply good |
| rail_pg_i | input | N_RAILS | Per-rail power-good |
| auth_ok_i | input | 1 | Authentication approval pulse |
| auth_fail_i | input | 1 | Authentication failure pulse |
| preauth_i | input | 1 | Cached pre-authorization level |
| pol_under_i | input | 2 | Policy for an early approval |
| pol_over_i | input | 2 | Policy for a missing approval or a failure |
| mcu_rst_n_o | output | 1 | Active-low processor reset |
| lock_o | output | 1 | Halted in lock verdict |
| degrade_req_o | output | 1 | Degraded-mode request |
| zeroize_req_o | output | 1 | Key-wipe request |
| cause_o | output | 3 | Last decision code |
| fail_cnt_o | output | FAIL_W | Saturating count of in-window failures |

## Verification
Several properties are checked every cycle. The released reset always implies qualified power-good. The filter outputs only move in the direction their inputs last held. A release only follows a window count at or above the lower bound. The verdict outputs stay mutually exclusive. The failure count only steps by one. A halt is left only toward the waiting state. Each low reset period reaches the minimum length. The exact window boundaries need the bench's timed scenarios. So do the policy mapping for each code, the treatment of the cached approval, the rejection of short pulses, the restart of the window after a power loss, and the point at which a halt is finally cleared.

// File: rtl/ars_pkg.sv
package ars_pkg;

  typedef enum logic [1:0] {
    ST_WAIT     = 2'd0,
    ST_WINDOW   = 2'd1,
    ST_RELEASED = 2'd2,
    ST_HALT     = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    CAUSE_NORMAL = 3'd0,
    CAUSE_UNDER  = 3'd1,
    CAUSE_OVER   = 3'd2,
    CAUSE_FAIL   = 3'd3,
    CAUSE_PGLOSS = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    POL_LOCK    = 2'd0,
    POL_DEGRADE = 2'd1,
    POL_ZEROIZE = 2'd2
  } policy_e;

  // Code 3 is folded onto lock so an unused encoding is never permissive.
  function automatic policy_e norm_policy(input logic [1:0] code);
    return (code == 2'd3) ? POL_LOCK : policy_e'(code);
  endfunction

endpackage

// File: rtl/ars_glitch_filter.sv
module ars_glitch_filter #(
  parameter int GLITCH_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  localparam int GW = $clog2(GLITCH_TICKS + 1);
  localparam logic [GW-1:0] G_LAST = GW'(GLITCH_TICKS - 1);

  logic [GW-1:0] cnt_q;
  logic          out_q;

  // The output follows only after the input has disagreed for GLITCH_TICKS samples.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (in_i == out_q) begin
      cnt_q <= '0;
    end else if (cnt_q == G_LAST) begin
      cnt_q <= '0;
      out_q <= in_i;
    end else begin
      cnt_q <= cnt_q + GW'(1);
    end
  end

  assign out_o = out_q;

  assert_rise_needs_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q) |-> $past(in_i));
  assert_fall_needs_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_q) |-> !$past(in_i));

endmodule

// File: rtl/ars_pg_qualifier.sv
module ars_pg_qualifier #(
  parameter int GLITCH_TICKS = 3,
  parameter int QUAL_TICKS   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic pg_q_o
);
  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_TICKS - 1);

  logic          pg_f;
  logic [QW-1:0] qcnt_q;
  logic          pg_q;

  ars_glitch_filter #(.GLITCH_TICKS(GLITCH_TICKS)) u_flt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (raw_i),
    .out_o (pg_f)
  );

  // Debounce and minimum-high share one run counter; any low restarts it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qcnt_q <= '0;
      pg_q   <= 1'b0;
    end else if (!pg_f) begin
      qcnt_q <= '0;
      pg_q   <= 1'b0;
    end else if (!pg_q) begin
      if (qcnt_q == Q_LAST) pg_q <= 1'b1;
      else                  qcnt_q <= qcnt_q + QW'(1);
    end
  end

  assign pg_q_o = pg_q;

  assert_loss_drops_qual_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_f |=> !pg_q);

endmodule

// File: rtl/ars_window_fsm.sv
module ars_window_fsm
  import ars_pkg::*;
#(
  parameter int KEY_MIN = 6,
  parameter int KEY_MAX = 20,
  parameter int FAIL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pg_q_i,
  input  logic              ok_rise_i,
  input  logic              fail_rise_i,
  input  logic              preauth_i,
  input  logic [1:0]        pol_under_i,
  input  logic [1:0]        pol_over_i,
  output logic              rel_req_o,
  output logic              lock_o,
  output logic              degrade_o,
  output logic              zeroize_o,
  output logic [2:0]        cause_o,
  output logic [FAIL_W-1:0] fail_cnt_o
);
  localparam int CW = $clog2(KEY_MAX + 1);
  localparam logic [CW-1:0] K_MIN = CW'(KEY_MIN);
  localparam logic [CW-1:0] K_MAX = CW'(KEY_MAX);

  seq_state_e        state_q;
  logic [CW-1:0]     win_cnt_q;
  cause_e            cause_q;
  policy_e           verdict_q;
  logic [FAIL_W-1:0] fail_cnt_q;
  logic              win_open;

  assign win_open = (win_cnt_q >= K_MIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WAIT;
      win_cnt_q  <= '0;
      cause_q    <= CAUSE_NORMAL;
      verdict_q  <= POL_LOCK;
      fail_cnt_q <= '0;
    end else if (state_q != ST_WAIT && !pg_q_i) begin
      state_q <= ST_WAIT;
      cause_q <= CAUSE_PGLOSS;
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (pg_q_i) begin
            state_q   <= ST_WINDOW;
            win_cnt_q <= '0;
          end
        end
        ST_WINDOW: begin
          if (fail_rise_i && win_open) begin
            state_q   <= ST_HALT;
            verdict_q <= norm_policy(pol_over_i);
            cause_q   <= CAUSE_FAIL;
            if (fail_cnt_q != '1) fail_cnt_q <= fail_cnt_q + FAIL_W'(1);
          end else if (ok_rise_i && !win_open) begin
            state_q   <= ST_HALT;
            verdict_q <= norm_policy(pol_under_i);
            cause_q   <= CAUSE_UNDER;
          end else if ((ok_rise_i || preauth_i) && win_open) begin
            state_q <= ST_RELEASED;
            cause_q <= CAUSE_NORMAL;
          end else if (win_cnt_q == K_MAX) begin
            state_q   <= ST_HALT;
            verdict_q <= norm_policy(pol_over_i);
            cause_q   <= CAUSE_OVER;
          end else begin
            win_cnt_q <= win_cnt_q + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign rel_req_o  = (state_q == ST_RELEASED);
  assign lock_o     = (state_q == ST_HALT) && (verdict_q == POL_LOCK);
  assign degrade_o  = (state_q == ST_HALT) && (verdict_q == POL_DEGRADE);
  assign zeroize_o  = (state_q == ST_HALT) && (verdict_q == POL_ZEROIZE);
  assign cause_o    = cause_q;
  assign fail_cnt_o = fail_cnt_q;

  assert_release_in_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RELEASED) && ($past(state_q) == ST_WINDOW) |-> ($past(win_cnt_q) >= K_MIN));
  assert_verdict_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lock_o, degrade_o, zeroize_o}));
  assert_fail_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_cnt_q != $past(fail_cnt_q)) |-> (fail_cnt_q == $past(fail_cnt_q) + FAIL_W'(1)));
  assert_halt_exit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_HALT) && (state_q != ST_HALT) |-> (state_q == ST_WAIT));

endmodule

// File: rtl/ars_reset_stretch.sv
module ars_reset_stretch #(
  parameter int RST_MIN_LOW = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rel_i,
  output logic rst_n_o
);
  localparam int LW = $clog2(RST_MIN_LOW + 1);
  localparam logic [LW-1:0] L_MIN = LW'(RST_MIN_LOW);

  logic [LW-1:0] low_q;
  logic          hi_q;
  logic          out_n;

  assign out_n = hi_q & rel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      if (out_n)              low_q <= '0;
      else if (low_q != L_MIN) low_q <= low_q + LW'(1);
      if (!rel_i)              hi_q <= 1'b0;
      else if (low_q == L_MIN) hi_q <= 1'b1;
    end
  end

  assign rst_n_o = out_n;

endmodule

// File: rtl/auth_rst_seq.sv
module auth_rst_seq
  import ars_pkg::*;
#(
  parameter int N_RAILS         = 3,
  parameter int GLITCH_TICKS    = 3,
  parameter int DEBOUNCE_TICKS  = 4,
  parameter int MIN_PULSE_TICKS = 4,
  parameter int KEY_MIN         = 6,
  parameter int KEY_MAX         = 20,
  parameter int RST_MIN_LOW     = 32,
  parameter int FAIL_W          = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               supply_ok_i,
  input  logic [N_RAILS-1:0] rail_pg_i,
  input  logic               auth_ok_i,
  input  logic               auth_fail_i,
  input  logic               preauth_i,
  input  logic [1:0]         pol_under_i,
  input  logic [1:0]         pol_over_i,
  output logic               mcu_rst_n_o,
  output logic               lock_o,
  output logic               degrade_req_o,
  output logic               zeroize_req_o,
  output logic [2:0]         cause_o,
  output logic [FAIL_W-1:0]  fail_cnt_o
);
  localparam int QUAL_TICKS = DEBOUNCE_TICKS + MIN_PULSE_TICKS;
  localparam int N_EVT      = 2;
  localparam int RW         = $clog2(RST_MIN_LOW + 2);
  localparam logic [RW-1:0] RUN_MIN = RW'(RST_MIN_LOW);

  logic             raw_pg;
  logic             pg_q;
  logic [N_EVT-1:0] evt_raw;
  logic [N_EVT-1:0] evt_rise;
  logic             rel_req;

  assign raw_pg  = supply_ok_i & (&rail_pg_i);
  assign evt_raw = {auth_fail_i, auth_ok_i};

  ars_pg_qualifier #(.GLITCH_TICKS(GLITCH_TICKS), .QUAL_TICKS(QUAL_TICKS)) u_pgq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (raw_pg),
    .pg_q_o(pg_q)
  );

  // Approval and failure lines share one filter-and-edge structure.
  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    logic filt;
    logic filt_d;
    ars_glitch_filter #(.GLITCH_TICKS(GLITCH_TICKS)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (evt_raw[i]),
      .out_o (filt)
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) filt_d <= 1'b0;
      else         filt_d <= filt;
    end
    assign evt_rise[i] = filt & ~filt_d;
  end

  ars_window_fsm #(.KEY_MIN(KEY_MIN), .KEY_MAX(KEY_MAX), .FAIL_W(FAIL_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pg_q_i     (pg_q),
    .ok_rise_i  (evt_rise[0]),
    .fail_rise_i(evt_rise[1]),
    .preauth_i  (preauth_i),
    .pol_under_i(pol_under_i),
    .pol_over_i (pol_over_i),
    .rel_req_o  (rel_req),
    .lock_o     (lock_o),
    .degrade_o  (degrade_req_o),
    .zeroize_o  (zeroize_req_o),
    .cause_o    (cause_o),
    .fail_cnt_o (fail_cnt_o)
  );

  ars_reset_stretch #(.RST_MIN_LOW(RST_MIN_LOW)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rel_i  (rel_req & pg_q),
    .rst_n_o(mcu_rst_n_o)
  );

  // Independent run-length counter of the reset output, for the pulse-width check.
  logic [RW-1:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     low_run_q <= '0;
    else if (mcu_rst_n_o)            low_run_q <= '0;
    else if (low_run_q != '1)        low_run_q <= low_run_q + RW'(1);
  end

  assert_release_needs_pg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcu_rst_n_o |-> pg_q);
  assert_min_low_width_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mcu_rst_n_o) |-> (low_run_q >= RUN_MIN));
  assert_zeroize_holds_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zeroize_req_o |-> !mcu_rst_n_o);

endmodule

// File: tb/auth_rst_seq_tb_top.sv
`timescale 1ns/1ps
module auth_rst_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b1;
  logic [2:0] rail = 3'b000;
  logic       auth_ok = 1'b0;
  logic       auth_fail = 1'b0;
  logic       preauth = 1'b0;
  logic [1:0] pol_under = 2'd0;
  logic [1:0] pol_over = 2'd0;
  logic       mcu_rst_n, lock, degrade, zeroize;
  logic [2:0] cause;
  logic [3:0] fail_cnt;

  int total = 0;
  int bad = 0;
  int exp_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  auth_rst_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .rail_pg_i(rail),
    .auth_ok_i(auth_ok), .auth_fail_i(auth_fail), .preauth_i(preauth),
    .pol_under_i(pol_under), .pol_over_i(pol_over), .mcu_rst_n_o(mcu_rst_n),
    .lock_o(lock), .degrade_req_o(degrade), .zeroize_req_o(zeroize),
    .cause_o(cause), .fail_cnt_o(fail_cnt)
  );

  // Table: approval tick, preauth, under policy, over policy, expected reset, cause, {lock,degrade,zeroize}.
  localparam int NV = 10;
  localparam int V_A1  [NV] = '{20, 15, 16, 30, 31,  0, 10,  0, 12, 11};
  localparam int V_PRE [NV] = '{ 0,  0,  0,  0,  0,  0,  0,  1,  0,  0};
  localparam int V_PU  [NV] = '{ 0,  0,  0,  0,  0,  0,  1,  0,  2,  3};
  localparam int V_PO  [NV] = '{ 0,  0,  0,  0,  1,  2,  0,  2,  0,  0};
  localparam int V_REL [NV] = '{ 1,  0,  1,  1,  0,  0,  0,  1,  0,  0};
  localparam int V_CAU [NV] = '{ 0,  1,  0,  0,  2,  2,  1,  0,  1,  1};
  localparam int V_FLG [NV] = '{ 0,  4,  0,  0,  2,  1,  2,  0,  1,  4};

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One power cycle: rails low 8 ticks, then rails high; events timed in ticks after the rise.
  task automatic boot(input int a1, input int alen, input int f1,
                      input int pre, input int pu, input int po, input int sup);
    @(negedge clk);
    rail = 3'b000;
    repeat (8) @(negedge clk);
    pol_under = 2'(pu);
    pol_over  = 2'(po);
    preauth   = pre[0];
    supply_ok = sup[0];
    rail      = 3'b111;
    for (int k = 1; k <= 45; k++) begin
      @(negedge clk);
      if (a1 > 0 && k == a1 - 1)        auth_ok = 1'b1;
      if (a1 > 0 && k == a1 - 1 + alen) auth_ok = 1'b0;
      if (f1 > 0 && k == f1 - 1)        auth_fail = 1'b1;
      if (f1 > 0 && k == f1 + 3)        auth_fail = 1'b0;
      if (k == 14) chk("R1 no release before window", int'(mcu_rst_n), 0);
    end
    preauth   = 1'b0;
    supply_ok = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset output low", int'(mcu_rst_n), 0);
    chk("R7 verdicts clear", int'({lock, degrade, zeroize}), 0);
    chk("R1 cause after reset", int'(cause), 0);
    chk("R9 fail count after reset", int'(fail_cnt), 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      boot(V_A1[i], 4, 0, V_PRE[i], V_PU[i], V_PO[i], 1);
      if (V_PRE[i] != 0)     tag = "R8 preauth";
      else if (V_REL[i] != 0) tag = "R4 window accept";
      else if (V_CAU[i] == 1) tag = "R5 under window";
      else                   tag = "R6 over window";
      chk(tag, int'(mcu_rst_n), V_REL[i]);
      chk(tag, int'(cause), V_CAU[i]);
      chk("R7 policy outputs", int'({lock, degrade, zeroize}), V_FLG[i]);
    end

    // R3: short dip on one rail while released
    boot(20, 4, 0, 0, 0, 0, 1);
    chk("R4 baseline release", int'(mcu_rst_n), 1);
    @(negedge clk); rail[1] = 1'b0;
    repeat (2) @(negedge clk); rail[1] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 rail glitch ignored", int'(mcu_rst_n), 1);
    chk("R3 cause unchanged", int'(cause), 0);

    // R10 and R11: power-good loss, then requalification and stretched release
    begin
      int lowcnt;
      bit seen_high;
      @(negedge clk); rail[0] = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10 reset drops on pg loss", int'(mcu_rst_n), 0);
      repeat (2) @(negedge clk);
      chk("R10 cause pg loss", int'(cause), 4);
      lowcnt = 3;
      seen_high = 1'b0;
      rail[0] = 1'b1;
      for (int k = 1; k <= 80; k++) begin
        @(negedge clk);
        if (k == 15) auth_ok = 1'b1;
        if (k == 19) auth_ok = 1'b0;
        if (!seen_high) begin
          if (mcu_rst_n) seen_high = 1'b1;
          else           lowcnt++;
        end
      end
      chk("R10 window restarted, release", int'(seen_high), 1);
      chk("R11 low width at least minimum", int'(lowcnt >= 32), 1);
      chk("R10 cause after re-release", int'(cause), 0);
    end

    // R3: approval pulse of 2 ticks never counts
    boot(20, 2, 0, 0, 0, 0, 1);
    chk("R3 short approval ignored", int'(mcu_rst_n), 0);
    chk("R3 short approval ends over window", int'(cause), 2);
    chk("R3 lock verdict", int'(lock), 1);

    // R9: failure before window ignored
    boot(22, 4, 12, 0, 0, 2, 1);
    chk("R9 early failure ignored", int'(mcu_rst_n), 1);
    chk("R9 count unchanged", int'(fail_cnt), exp_fail);

    // R9: failure inside window
    boot(0, 4, 18, 0, 0, 2, 1);
    exp_fail++;
    chk("R9 failure zeroize", int'(zeroize), 1);
    chk("R9 failure cause", int'(cause), 3);
    chk("R9 count step", int'(fail_cnt), exp_fail);

    // R12: halted verdict ignores approvals
    @(negedge clk); auth_ok = 1'b1;
    repeat (4) @(negedge clk); auth_ok = 1'b0;
    repeat (10) @(negedge clk);
    chk("R12 halt holds zeroize", int'(zeroize), 1);
    chk("R12 halt holds reset", int'(mcu_rst_n), 0);
    boot(20, 4, 0, 0, 0, 0, 1);
    chk("R12 exit via requalification", int'(mcu_rst_n), 1);
    chk("R12 zeroize cleared", int'(zeroize), 0);

    // R2: high shorter than qualification time
    @(negedge clk); rail = 3'b000;
    repeat (8) @(negedge clk);
    pol_over = 2'd2;
    rail = 3'b111;
    repeat (7) @(negedge clk);
    rail = 3'b000;
    repeat (45) @(negedge clk);
    chk("R2 short high never qualifies", int'(zeroize), 0);
    chk("R2 reset held", int'(mcu_rst_n), 0);
    chk("R2 cause unchanged", int'(cause), 4);

    // R2: supply low with all rails high
    boot(20, 4, 0, 0, 0, 0, 0);
    chk("R2 supply gates power-good", int'(mcu_rst_n), 0);
    chk("R2 no verdict without supply", int'(lock), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule